// File: doc/BRIEF.md
# TDM Bus-Master Transfer Sequencer

This block makes a serial TDM port act as the master of a parallel bus, so that no external bus controller is needed. It follows the frame pulse and the bit clock. For every valid channel it drives a buffer address, an output-enable strobe to fetch transmit data and a write-enable strobe to store received data. It also drives a start-of-channel pulse, plus a delayed chip select that lets a second unit share the same parallel bus in a daisy chain. Every strobe changes on the bit clock, so the block never has to arbitrate an access.

Each timeslot is eight bit cells and a frame holds 32 timeslots. With the channel-count select high, all 32 timeslots are valid and map to buffer positions 0 to 31. With it low, every fourth timeslot (0, 4, 8, …, 28) carries forced all-ones data. Those timeslots are skipped, and the other 24 map to consecutive buffer positions 0 to 23. Alongside the bus sequencing, the serial input is stored in a 32-byte circular buffer and replayed on the loop output exactly one frame later.

The sequencer is a four-state machine. HUNT is entered from reset and waits for the first frame pulse. FETCH covers the first half of a valid timeslot. STORE covers the second half of a valid timeslot. SKIP covers a whole invalid timeslot. The transitions are:
- Frame pulse: from any state to FETCH or SKIP, according to the validity of timeslot 0.
- Half point: FETCH moves to STORE at the half point of the timeslot.
- End of timeslot: STORE or SKIP moves to FETCH or SKIP, according to the validity of the next timeslot.
- Otherwise the state holds.

Top module: `tdm_bus_sequencer`

## Requirements
- R1: While reset is applied, and after reset until the first frame pulse, `oe_n`, `we_n`, `chan_start_n` and `dly_cs_n` are high, `addr_o` is 0 and `loop_out` is 1.
- R2: When `frm_n` is sampled low on a rising clock edge, the next clock cycle is bit cell 0 of timeslot 0. Each timeslot then lasts 8 cycles, and after timeslot 31 the count wraps to timeslot 0.
- R3: `chan_start_n` is low during bit cells 0 to 3 of every valid timeslot and high at all other times.
- R4: `dly_cs_n` is low during bit cells 4 to 7 of every valid timeslot and high at all other times.
- R5: `oe_n` is low exactly when `chan_start_n` is low, and `we_n` is low exactly when `dly_cs_n` is low. The two strobes are never low together.
- R6: With `sel32` = 1, every timeslot is valid and `addr_o` equals the timeslot index throughout the timeslot.
- R7: With `sel32` = 0, a timeslot whose index is a multiple of 4 is invalid: no strobe or pulse is low and `addr_o` is 0. Valid timeslot t drives `addr_o` = 3·(t/4) + (t mod 4) − 1, so timeslot 1 maps to 0 and timeslot 31 maps to 23.
- R8: The value of `loop_out` in bit cell b of timeslot t equals the value `ser_in` had in bit cell b of timeslot t one frame earlier.
- R9: The loop buffer resets to all ones, so `loop_out` is 1 throughout the first frame after reset.
- R10: A frame pulse that arrives in mid-frame restarts the count at timeslot 0, bit cell 0 on the next cycle. Regular timeslot timing follows from there.
- R11: The loop path covers all 32 timeslots whatever the value of `sel32`, including the timeslots that are skipped in 24-channel operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one cycle per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_n | input | 1 | Active-low frame pulse; the next cycle is timeslot 0, bit cell 0 |
| sel32 | input | 1 | 1 = 32-channel operation, 0 = 24-channel operation |
| ser_in | input | 1 | Serial receive data, one bit per cell |
| addr_o | output | 5 | Buffer position for the current timeslot |
| oe_n | output | 1 | Active-low output enable (transmit fetch) |
| we_n | output | 1 | Active-low write enable (receive store) |
| chan_start_n | output | 1 | Active-low start-of-channel pulse, four bit cells |
| dly_cs_n | output | 1 | Active-low delayed chip select, last four bit cells |
| loop_out | output | 1 | Serial input replayed one frame later |

## Verification
A wrong state or a slipped count shows at the ports within one timeslot. A half-point transition made on the wrong cell moves the edge between the `chan_start_n` and `dly_cs_n` pulses within eight cycles. A wrong validity decision for the next timeslot puts strobes on a skipped timeslot, or removes them from a valid one, in the very next timeslot. Faults in the loop buffer, such as a wrong write cell, reversed bit order or a missing reset to ones, only appear one frame (256 cycles) later. For that reason every bit cell of `loop_out` is compared against the serial input recorded in the frame before.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2,
        ST_SKIP  = 2'd3
    } seq_state_t;

    // A timeslot is live unless 24-channel operation forces it to all ones.
    function automatic logic slot_live(input int unsigned slot,
                                       input logic        full,
                                       input int unsigned group);
        return full || ((slot % group) != 0);
    endfunction

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frm_n,
    output logic                         synced,
    output logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    output logic [$clog2(SLOTS)-1:0]     slot_idx,
    output logic                         last_bit,
    output logic [$clog2(SLOTS)-1:0]     next_slot
);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    assign last_bit  = (bit_idx == LAST_BIT);
    assign next_slot = (slot_idx == LAST_SLOT) ? '0 : slot_idx + SW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            synced   <= 1'b0;
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (!frm_n) begin
            synced   <= 1'b1;
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (synced) begin
            if (last_bit) begin
                bit_idx  <= '0;
                slot_idx <= next_slot;
            end else begin
                bit_idx  <= bit_idx + BW'(1);
            end
        end
    end

    // R2: inside a timeslot the bit cell advances by exactly one.
    assert_bit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (synced && frm_n && !last_bit) |=> (bit_idx == $past(bit_idx) + BW'(1)));

    // R10: a frame pulse restarts the count at timeslot 0, bit cell 0.
    assert_resync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_n |=> (synced && bit_idx == '0 && slot_idx == '0));

endmodule

// File: rtl/tdm_slot_map.sv
module tdm_slot_map #(
    parameter int SLOTS = 32,
    parameter int GROUP = 4
) (
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic                     full,
    output logic                     valid,
    output logic [$clog2(SLOTS)-1:0] addr
);
    localparam int SW = $clog2(SLOTS);

    logic [SW-1:0] grp_cnt;

    always_comb begin
        grp_cnt = slot / SW'(GROUP);
        valid   = full || ((slot % SW'(GROUP)) != '0);
        if (full) begin
            addr = slot;
        end else if (valid) begin
            // one forced slot precedes each group, plus the one at slot 0
            addr = slot - grp_cnt - SW'(1);
        end else begin
            addr = '0;
        end
    end

endmodule

// File: rtl/tdm_loop_buffer.sv
module tdm_loop_buffer #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         synced,
    input  logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    input  logic [$clog2(SLOTS)-1:0]     slot_idx,
    input  logic                         ser_in,
    output logic                         loop_out
);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_BITS - 1);

    logic [SLOT_BITS-1:0] ring [SLOTS];
    logic [SLOT_BITS-2:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                ring[i] <= '1;
            end
        end else if (synced) begin
            acc <= {acc[SLOT_BITS-3:0], ser_in};
            if (bit_idx == LAST_BIT) begin
                ring[slot_idx] <= {acc, ser_in};
            end
        end
    end

    // first received cell sits in the MSB, so replay runs MSB first
    assign loop_out = synced ? ring[slot_idx][LAST_BIT - bit_idx] : 1'b1;

    // R1: nothing but idle ones leaves the loop path before alignment.
    assert_idle_loop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!synced && $past(!synced)) |-> loop_out);

endmodule

// File: rtl/tdm_bus_sequencer.sv
module tdm_bus_sequencer
    import tdm_seq_pkg::*;
#(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8,
    parameter int GROUP     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frm_n,
    input  logic                     sel32,
    input  logic                     ser_in,
    output logic [$clog2(SLOTS)-1:0] addr_o,
    output logic                     oe_n,
    output logic                     we_n,
    output logic                     chan_start_n,
    output logic                     dly_cs_n,
    output logic                     loop_out
);
    localparam int SW = $clog2(SLOTS);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [BW-1:0] HALF_LAST = BW'(SLOT_BITS / 2 - 1);
    localparam logic [BW-1:0] HALF      = BW'(SLOT_BITS / 2);
    localparam logic [SW-1:0] LIVE_CNT  = SW'(SLOTS - SLOTS / GROUP);

    logic          synced;
    logic [BW-1:0] bit_idx;
    logic [SW-1:0] slot_idx;
    logic          last_bit;
    logic [SW-1:0] next_slot;
    logic          cur_valid;
    logic [SW-1:0] cur_addr;
    logic [SW-1:0] entry_slot;
    logic          entry_live;

    seq_state_t state_q, state_d;

    tdm_slot_counter #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_n    (frm_n),
        .synced   (synced),
        .bit_idx  (bit_idx),
        .slot_idx (slot_idx),
        .last_bit (last_bit),
        .next_slot(next_slot)
    );

    tdm_slot_map #(.SLOTS(SLOTS), .GROUP(GROUP)) u_map (
        .slot (slot_idx),
        .full (sel32),
        .valid(cur_valid),
        .addr (cur_addr)
    );

    tdm_loop_buffer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .synced  (synced),
        .bit_idx (bit_idx),
        .slot_idx(slot_idx),
        .ser_in  (ser_in),
        .loop_out(loop_out)
    );

    assign entry_slot = frm_n ? next_slot : '0;
    assign entry_live = slot_live(32'(entry_slot), sel32, GROUP);

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!frm_n) begin
            state_d = entry_live ? ST_FETCH : ST_SKIP;
        end else begin
            unique case (state_q)
                ST_HUNT:  state_d = ST_HUNT;
                ST_FETCH: if (bit_idx == HALF_LAST) state_d = ST_STORE;
                ST_STORE: if (last_bit) state_d = entry_live ? ST_FETCH : ST_SKIP;
                ST_SKIP:  if (last_bit) state_d = entry_live ? ST_FETCH : ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        oe_n         = 1'b1;
        we_n         = 1'b1;
        chan_start_n = 1'b1;
        dly_cs_n     = 1'b1;
        addr_o       = '0;
        unique case (state_q)
            ST_HUNT: ;
            ST_FETCH: begin
                oe_n         = 1'b0;
                chan_start_n = 1'b0;
                addr_o       = cur_valid ? cur_addr : '0;
            end
            ST_STORE: begin
                we_n     = 1'b0;
                dly_cs_n = 1'b0;
                addr_o   = cur_valid ? cur_addr : '0;
            end
            ST_SKIP: ;
        endcase
    end

    // R3: start-of-channel pulse only in the first half of a timeslot
    assert_start_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_start_n |-> (synced && bit_idx < HALF));

    // R4: delayed chip select only in the second half of a timeslot
    assert_dlycs_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_cs_n |-> (synced && bit_idx >= HALF));

    // R5: fetch strobe hands over to store strobe at the half point
    assert_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && bit_idx == HALF_LAST && frm_n) |=> (!we_n && oe_n));

    // R7: forced timeslots in 24-channel operation stay quiet
    assert_skip_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (synced && !sel32 && (slot_idx % SW'(GROUP)) == '0) |-> (oe_n && we_n));

    // R7: 24-channel addresses stay inside the live range
    assert_addr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel32 && !oe_n) |-> (addr_o < LIVE_CNT));

endmodule

// File: tb/sim_tdm_bus_sequencer.sv
`timescale 1ns/1ps
module sim_tdm_bus_sequencer;

    logic       clk = 1'b0;
    logic       rst_n, frm_n, sel32, ser_in;
    logic [4:0] addr_o;
    logic       oe_n, we_n, chan_start_n, dly_cs_n, loop_out;

    always #2.5 clk = ~clk;

    tdm_bus_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .sel32(sel32), .ser_in(ser_in),
        .addr_o(addr_o), .oe_n(oe_n), .we_n(we_n), .chan_start_n(chan_start_n),
        .dly_cs_n(dly_cs_n), .loop_out(loop_out)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic prev_bits [256];
    logic cur_bits  [256];
    logic [15:0] lfsr = 16'hACE1;
    int   obs_addr [32];
    logic obs_oe   [32];

    // 24-channel map vectors: timeslot, expected address (-1 = skipped)
    localparam int NVEC = 10;
    localparam int TAB_SLOT [NVEC] = '{0, 1, 2, 3, 4, 5, 7, 13, 28, 31};
    localparam int TAB_ADDR [NVEC] = '{-1, 0, 1, 2, -1, 3, 5, 9, -1, 23};

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string tag);
        check({oe_n, we_n, chan_start_n, dly_cs_n}, 4'hF, tag);
        check(addr_o, 0, tag);
        check(loop_out, 1, tag);
    endtask

    // Entered at the falling edge of timeslot 0, bit cell 0.
    task automatic run_frame(input bit mode, input bit next_mode, input bit first, input bit record);
        for (int p = 0; p < 256; p++) begin
            int   slot = p / 8;
            int   b    = p % 8;
            bit   live = mode || (slot % 4 != 0);
            logic exp_start = !(live && b < 4);
            logic exp_dly   = !(live && b >= 4);
            int   exp_addr  = !live ? 0 : (mode ? slot : 3 * (slot / 4) + slot % 4 - 1);
            check(chan_start_n, exp_start, "R3 start pulse");
            check(dly_cs_n, exp_dly, "R4 delayed select");
            check({oe_n, we_n}, {exp_start, exp_dly}, "R5 strobes");
            if (mode) check(addr_o, exp_addr, "R6 address");
            else      check(addr_o, exp_addr, "R7 address");
            if (first)     check(loop_out, 1, "R9 reset ones");
            else if (mode) check(loop_out, prev_bits[p], "R8 loop");
            else           check(loop_out, prev_bits[p], "R11 loop in 24 mode");
            if (record && b == 1) begin
                obs_addr[slot] = addr_o;
                obs_oe[slot]   = oe_n;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cur_bits[p] = lfsr[0];
            ser_in = lfsr[0];
            frm_n  = (p == 255) ? 1'b0 : 1'b1;
            if (p == 255) sel32 = next_mode;
            @(negedge clk);
        end
        for (int i = 0; i < 256; i++) prev_bits[i] = cur_bits[i];
    endtask

    initial begin
        rst_n = 1'b0; frm_n = 1'b1; sel32 = 1'b1; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check_idle("R1 before frame pulse");

        frm_n = 1'b0;
        @(negedge clk);
        run_frame(1'b1, 1'b1, 1'b1, 1'b0);   // R9 first frame all ones
        run_frame(1'b1, 1'b0, 1'b0, 1'b0);   // R8 one-frame replay
        run_frame(1'b0, 1'b0, 1'b0, 1'b1);   // R7, R11 in 24 mode

        for (int v = 0; v < NVEC; v++) begin
            if (TAB_ADDR[v] < 0) begin
                check(obs_oe[TAB_SLOT[v]], 1, "R7 skipped slot quiet");
            end else begin
                check(obs_oe[TAB_SLOT[v]], 0, "R7 live slot fetch");
                check(obs_addr[TAB_SLOT[v]], TAB_ADDR[v], "R7 map vector");
            end
        end

        run_frame(1'b0, 1'b1, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 1'b0, 1'b0);   // R2 wrap held over several frames

        // R10: mid-frame pulse at timeslot 12, bit cell 4
        for (int p = 0; p < 100; p++) begin
            frm_n = 1'b1;
            @(negedge clk);
        end
        check(addr_o, 12, "R10 pre-resync slot");
        frm_n = 1'b0;
        @(negedge clk);
        frm_n = 1'b1;
        check(chan_start_n, 0, "R10 restart pulse");
        check(dly_cs_n, 1, "R10 restart select");
        check(addr_o, 0, "R10 restart address");
        repeat (4) @(negedge clk);
        check(dly_cs_n, 0, "R10 half point after restart");
        repeat (4) @(negedge clk);
        check(addr_o, 1, "R2 next timeslot after restart");
        check(chan_start_n, 0, "R2 next timeslot pulse");

        // reset during operation
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 reset mid-run");
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check_idle("R1 hunting after reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule